// File: doc/BRIEF.md
# Command-Loss Watchdog with Safe Output Shutdown

This block sits between a motion controller's command path and its actuator output registers. Software or a link interface writes new command words into a bank of output registers, then pulses an update strobe to mark a complete command set. Updates are expected once per servo period. A single missed period is harmless: the registers simply keep the last values written.

A timeout counter, stepped by ticks from an external prescaler, measures the gap since the most recent update. If the gap reaches the configured number of ticks, every gated output is forced to zero and an emergency-stop flag latches. The flag never releases on its own. A fresh update must arrive first, and only then does an explicit clear pulse release it. Reset leaves the block tripped with all outputs at zero, so the actuators stay idle until the first update and a clear.

Top module: `cmd_loss_guard`

## Requirements
- R1: Reset (synchronous, active high) clears every register to zero, empties the timeout counter and sets estop_o to 1. After reset an update followed by a clear shows all outputs at zero.
- R2: When bit k of wr_en_i is high at a clock edge, register k stores wr_data_i. Register k drives out_o[k*DATA_W +: DATA_W], and with estop_o low the new value shows there from the cycle after the edge. Other registers are unchanged.
- R3: A register whose write enable is low keeps its value. Ticks that come without an update do not change the outputs while the timeout has not run out.
- R4: An update strobe reloads the timeout counter to TIMEOUT_TICKS. Each tick_i pulse without an update lowers it by one. When an update and a tick coincide, the reload wins.
- R5: After an update, TIMEOUT_TICKS-1 ticks leave estop_o low. The tick that brings the count to zero sets estop_o at that clock edge, and all outputs read zero from the next cycle.
- R6: Once set, estop_o stays set after updates resume, for as long as no accepted clear arrives.
- R7: estop_clr_i releases estop_o only if an update was registered in an earlier cycle since the flag was last set or since reset. A clear with no such update is ignored. A clear in the same cycle as the first update is also ignored.
- R8: While estop_o is 1, register writes are still stored but every output reads zero. The stored values appear on out_o once the flag is cleared.
- R9: If the counter runs out in the same cycle as an otherwise valid clear, the expiry wins: estop_o stays 1, and the pending update no longer counts, so a later clear alone is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_i | input | 1 | Update strobe marking a complete command set |
| tick_i | input | 1 | Prescaled timebase tick |
| wr_en_i | input | NUM_REGS | Per-register write enable |
| wr_data_i | input | DATA_W | Write data shared by all registers |
| estop_clr_i | input | 1 | Emergency-stop clear request |
| out_o | output | NUM_REGS*DATA_W | Gated register outputs, register k at bits k*DATA_W upward |
| estop_o | output | 1 | Latched emergency-stop flag |

## Verification
The hardest case to reach is a clear that arrives while the block is armed and on exactly the tick that exhausts the counter. To get there, the stimulus trips the block by timeout, sends one update without clearing, counts out TIMEOUT_TICKS-1 ticks, and then drives the last tick together with the clear. A clear on its own follows, to confirm that the armed condition was dropped. The stimulus also drives a clear in the same cycle as an update, and an update and a tick in the same cycle, to pin down the priority rules.

// File: rtl/cmd_guard_pkg.sv
package cmd_guard_pkg;

    localparam int unsigned DEF_NUM_REGS      = 8;
    localparam int unsigned DEF_DATA_W        = 16;
    localparam int unsigned DEF_TIMEOUT_TICKS = 5;

    // Guard state: two tripped flavours and the running state
    typedef enum logic [1:0] {
        GUARD_TRIP_IDLE  = 2'b01,
        GUARD_TRIP_ARMED = 2'b10,
        GUARD_RUN        = 2'b00
    } guard_state_e;

    // Control strobes bundled for the state update
    typedef struct packed {
        logic upd;
        logic clr;
        logic expire;
    } guard_ctl_t;

    function automatic guard_state_e guard_next(guard_state_e cur, guard_ctl_t ctl);
        guard_state_e nxt;
        nxt = cur;
        if (ctl.expire) begin
            nxt = GUARD_TRIP_IDLE;
        end else begin
            case (cur)
                GUARD_TRIP_IDLE:  if (ctl.upd) nxt = GUARD_TRIP_ARMED;
                GUARD_TRIP_ARMED: if (ctl.clr) nxt = GUARD_RUN;
                GUARD_RUN:        nxt = GUARD_RUN;
                default:          nxt = GUARD_TRIP_IDLE;
            endcase
        end
        return nxt;
    endfunction

    function automatic logic guard_tripped(guard_state_e st);
        return (st != GUARD_RUN);
    endfunction

endpackage

// File: rtl/cmd_reg_bank.sv
module cmd_reg_bank #(
    parameter int unsigned NUM_REGS = cmd_guard_pkg::DEF_NUM_REGS,
    parameter int unsigned DATA_W   = cmd_guard_pkg::DEF_DATA_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_REGS-1:0]        wr_en_i,
    input  logic [DATA_W-1:0]          wr_data_i,
    output logic [NUM_REGS*DATA_W-1:0] bank_o
);

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
        logic [DATA_W-1:0] word_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                word_q <= '0;
            end else if (wr_en_i[k]) begin
                word_q <= wr_data_i;
            end
        end

        assign bank_o[k*DATA_W +: DATA_W] = word_q;

        assert_write_stores_R2: assert property (@(posedge clk) disable iff (rst)
            wr_en_i[k] |=> (bank_o[k*DATA_W +: DATA_W] == $past(wr_data_i)));

        assert_word_holds_R3: assert property (@(posedge clk) disable iff (rst)
            !wr_en_i[k] |=> $stable(bank_o[k*DATA_W +: DATA_W]));
    end

endmodule

// File: rtl/cmd_timeout_timer.sv
module cmd_timeout_timer #(
    parameter int unsigned TIMEOUT_TICKS = cmd_guard_pkg::DEF_TIMEOUT_TICKS
) (
    input  logic clk,
    input  logic rst,
    input  logic upd_i,
    input  logic tick_i,
    output logic expire_o,
    output logic live_o
);

    localparam int unsigned CNT_W = $clog2(TIMEOUT_TICKS + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(TIMEOUT_TICKS);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (upd_i) begin
            cnt_d = CNT_FULL;
        end else if (tick_i && (cnt_q != '0)) begin
            cnt_d = cnt_q - CNT_LAST;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expire_o = tick_i && !upd_i && (cnt_q == CNT_LAST);
    assign live_o   = (cnt_q != '0);

    assert_update_reloads_R4: assert property (@(posedge clk) disable iff (rst)
        upd_i |=> live_o);

    assert_idle_holds_count_R4: assert property (@(posedge clk) disable iff (rst)
        (!upd_i && !tick_i) |=> $stable(cnt_q));

    assert_expiry_empties_R5: assert property (@(posedge clk) disable iff (rst)
        expire_o |=> !live_o);

endmodule

// File: rtl/cmd_estop_latch.sv
module cmd_estop_latch
    import cmd_guard_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic upd_i,
    input  logic clr_i,
    input  logic expire_i,
    output logic estop_o
);

    guard_state_e state_q;
    guard_ctl_t   ctl;

    always_comb begin
        ctl.upd    = upd_i;
        ctl.clr    = clr_i;
        ctl.expire = expire_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= GUARD_TRIP_IDLE;
        end else begin
            state_q <= guard_next(state_q, ctl);
        end
    end

    assign estop_o = guard_tripped(state_q);

    assert_expiry_trips_R5: assert property (@(posedge clk) disable iff (rst)
        expire_i |=> estop_o);

    assert_stays_latched_R6: assert property (@(posedge clk) disable iff (rst)
        (estop_o && !clr_i) |=> estop_o);

    assert_release_needs_arming_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(estop_o) |-> ($past(clr_i) && ($past(state_q) == GUARD_TRIP_ARMED)));

    assert_expiry_beats_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (expire_i && clr_i) |=> (state_q == GUARD_TRIP_IDLE));

endmodule

// File: rtl/cmd_out_gate.sv
module cmd_out_gate #(
    parameter int unsigned NUM_REGS = cmd_guard_pkg::DEF_NUM_REGS,
    parameter int unsigned DATA_W   = cmd_guard_pkg::DEF_DATA_W
) (
    input  logic                       estop_i,
    input  logic [NUM_REGS*DATA_W-1:0] bank_i,
    output logic [NUM_REGS*DATA_W-1:0] out_o
);

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_lane
        assign out_o[k*DATA_W +: DATA_W] =
            bank_i[k*DATA_W +: DATA_W] & {DATA_W{!estop_i}};
    end

endmodule

// File: rtl/cmd_loss_guard.sv
module cmd_loss_guard #(
    parameter int unsigned NUM_REGS      = cmd_guard_pkg::DEF_NUM_REGS,
    parameter int unsigned DATA_W        = cmd_guard_pkg::DEF_DATA_W,
    parameter int unsigned TIMEOUT_TICKS = cmd_guard_pkg::DEF_TIMEOUT_TICKS
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       upd_i,
    input  logic                       tick_i,
    input  logic [NUM_REGS-1:0]        wr_en_i,
    input  logic [DATA_W-1:0]          wr_data_i,
    input  logic                       estop_clr_i,
    output logic [NUM_REGS*DATA_W-1:0] out_o,
    output logic                       estop_o
);

    localparam int unsigned BANK_W = NUM_REGS * DATA_W;

    logic [BANK_W-1:0] bank;
    logic              expire;
    logic              live;

    cmd_reg_bank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .bank_o    (bank)
    );

    cmd_timeout_timer #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .upd_i    (upd_i),
        .tick_i   (tick_i),
        .expire_o (expire),
        .live_o   (live)
    );

    cmd_estop_latch u_latch (
        .clk      (clk),
        .rst      (rst),
        .upd_i    (upd_i),
        .clr_i    (estop_clr_i),
        .expire_i (expire),
        .estop_o  (estop_o)
    );

    cmd_out_gate #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_gate (
        .estop_i (estop_o),
        .bank_i  (bank),
        .out_o   (out_o)
    );

    assert_tripped_outputs_zero_R8: assert property (@(posedge clk) disable iff (rst)
        estop_o |-> (out_o == '0));

    assert_running_needs_live_timer_R5: assert property (@(posedge clk) disable iff (rst)
        !estop_o |-> live);

endmodule

// File: tb/test_cmd_loss_guard.sv
`timescale 1ns/1ps
module test_cmd_loss_guard;

    localparam int NR = 8;
    localparam int DW = 16;
    localparam int TO = 5;

    logic          clk = 1'b0;
    logic          rst;
    logic          upd, tick, clr;
    logic [NR-1:0] wen;
    logic [DW-1:0] wdata;
    logic [NR*DW-1:0] out;
    logic          estop;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    cmd_loss_guard #(.NUM_REGS(NR), .DATA_W(DW), .TIMEOUT_TICKS(TO)) i_cmd_loss_guard (
        .clk(clk), .rst(rst), .upd_i(upd), .tick_i(tick), .wr_en_i(wen),
        .wr_data_i(wdata), .estop_clr_i(clr), .out_o(out), .estop_o(estop)
    );

    typedef struct packed {
        logic          upd;
        logic          tick;
        logic          clr;
        logic [7:0]    wen;
        logic [15:0]   data;
        logic          exp_estop;
        logic [15:0]   exp_r0;
        logic [7:0]    req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,1'b0,8'h01,16'hA5A5,1'b1,16'h0000,8'd8}, // R8 write while tripped
        '{1'b0,1'b0,1'b1,8'h00,16'h0000,1'b1,16'h0000,8'd7}, // R7 clear, no update
        '{1'b1,1'b0,1'b1,8'h00,16'h0000,1'b1,16'h0000,8'd7}, // R7 clear with update same cycle
        '{1'b0,1'b0,1'b1,8'h00,16'h0000,1'b0,16'hA5A5,8'd8}, // R8 stored value appears
        '{1'b0,1'b1,1'b0,8'h00,16'h0000,1'b0,16'hA5A5,8'd3}, // R3 tick keeps outputs
        '{1'b0,1'b0,1'b0,8'h01,16'h1234,1'b0,16'h1234,8'd2}, // R2 write visible
        '{1'b0,1'b1,1'b0,8'h00,16'h0000,1'b0,16'h1234,8'd3}, // R3
        '{1'b0,1'b1,1'b0,8'h00,16'h0000,1'b0,16'h1234,8'd3}, // R3
        '{1'b0,1'b1,1'b0,8'h00,16'h0000,1'b0,16'h1234,8'd5}, // R5 fourth tick still clear
        '{1'b1,1'b0,1'b0,8'h00,16'h0000,1'b0,16'h1234,8'd4}, // R4 reload
        '{1'b1,1'b1,1'b0,8'h00,16'h0000,1'b0,16'h1234,8'd4}, // R4 update beats tick
        '{1'b0,1'b1,1'b0,8'h00,16'h0000,1'b0,16'h1234,8'd4}, // R4
        '{1'b0,1'b1,1'b0,8'h00,16'h0000,1'b0,16'h1234,8'd4}, // R4
        '{1'b0,1'b1,1'b0,8'h00,16'h0000,1'b0,16'h1234,8'd4}, // R4
        '{1'b0,1'b1,1'b0,8'h00,16'h0000,1'b0,16'h1234,8'd5}, // R5 one tick left
        '{1'b0,1'b1,1'b0,8'h00,16'h0000,1'b1,16'h0000,8'd5}, // R5 expiry trips
        '{1'b1,1'b0,1'b0,8'h00,16'h0000,1'b1,16'h0000,8'd6}, // R6 update, still latched
        '{1'b0,1'b1,1'b0,8'h00,16'h0000,1'b1,16'h0000,8'd6}, // R6
        '{1'b0,1'b0,1'b1,8'h00,16'h0000,1'b0,16'h1234,8'd7}  // R7 armed clear accepted
    };

    task automatic check_val(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic u, input logic t, input logic c,
                        input logic [NR-1:0] we, input logic [DW-1:0] d);
        upd = u; tick = t; clr = c; wen = we; wdata = d;
        @(negedge clk);
        upd = 1'b0; tick = 1'b0; clr = 1'b0; wen = '0; wdata = '0;
    endtask

    initial begin
        #(5.0 * 20000);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; upd = 0; tick = 0; clr = 0; wen = '0; wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check_val("R1 estop after reset", {31'd0, estop}, 32'd1);
        check_val("R1 outputs after reset", {31'd0, |out}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            step(VECS[i].upd, VECS[i].tick, VECS[i].clr, VECS[i].wen, VECS[i].data);
            check_val($sformatf("R%0d vector %0d", VECS[i].req, i),
                      {15'd0, estop, out[15:0]},
                      {15'd0, VECS[i].exp_estop, VECS[i].exp_r0});
        end

        // R2 write top register, others untouched
        step(1'b0, 1'b0, 1'b0, 8'h80, 16'hBEEF);
        check_val("R2 reg7", {16'd0, out[7*DW +: DW]}, 32'h0000BEEF);
        check_val("R2 reg0 untouched", {16'd0, out[15:0]}, 32'h00001234);
        check_val("R2 reg3 untouched", {16'd0, out[3*DW +: DW]}, 32'h0);

        // R9: trip by timeout, arm, then expiry coincides with clear
        repeat (TO) step(1'b0, 1'b1, 1'b0, '0, '0);
        check_val("R5 tripped again", {31'd0, estop}, 32'd1);
        step(1'b1, 1'b0, 1'b0, '0, '0);
        repeat (TO - 1) step(1'b0, 1'b1, 1'b0, '0, '0);
        step(1'b0, 1'b1, 1'b1, '0, '0);
        check_val("R9 expiry beats clear", {31'd0, estop}, 32'd1);
        step(1'b0, 1'b0, 1'b1, '0, '0);
        check_val("R9 arming dropped", {31'd0, estop}, 32'd1);
        check_val("R8 outputs zero while tripped", {31'd0, |out}, 32'd0);

        // R1 reset mid-run clears bank
        step(1'b1, 1'b0, 1'b0, '0, '0);
        step(1'b0, 1'b0, 1'b1, '0, '0);
        check_val("R7 released before reset", {31'd0, estop}, 32'd0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_val("R1 estop after mid-run reset", {31'd0, estop}, 32'd1);
        step(1'b1, 1'b0, 1'b0, '0, '0);
        step(1'b0, 1'b0, 1'b1, '0, '0);
        check_val("R1 released", {31'd0, estop}, 32'd0);
        check_val("R1 bank cleared", {31'd0, |out}, 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule